// File: doc/BRIEF.md
# OTP Fuse Access Controller

This block gives software a small register window onto a one-time-programmable fuse array. A control register carries a 16-bit write-unlock key, the fuse word address (bank times 8 plus word) and two flags: a busy flag and a sticky error flag. Writing the read-control register senses the addressed word into a result register. Writing the program-data register, with the correct key loaded, burns the data into the addressed word.

Every operation runs as three timed phases: a lead relax, the asserted fuse strobe and a trailing relax. All phase lengths are taken from a timing register and counted in clock cycles. Each strobe count is the length of the whole operation, so the relax time on both sides is taken out of it. The fuse array here is a synthesizable model in which programming can only set bits. Illegal starts raise the error flag, which stays set until it is cleared through a write-one-to-clear alias of the control register.

Register word offsets on `addr_i`: 0 control, 1 control clear alias, 2 timing, 3 read control, 4 program data, 5 sense result. Offsets 3, 4, 6 and 7 read as zero, and offset 1 reads the same value as offset 0.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset the control, timing and sense-result registers read 0, and `strobe_o` is low.
- R2: The control register holds the unlock key in bits 31:16 and the word address in bits 6:0, and reads busy at bit 8 and error at bit 9. Both flags are read-only there. A control write while busy is ignored.
- R3: The timing register holds the program strobe count in bits 11:0, the relax count in bits 15:12 and the read strobe count in bits 21:16. Its other bits read 0, and a write to it while busy is ignored.
- R4: Writing 1 to bit 0 of read control (offset 3) senses the word at the control address. Once busy clears, offset 5 returns that word.
- R5: Writing offset 4 while bits 31:16 of control hold 0x3E77 starts a program cycle. The cycle ORs the data into the addressed word, so a bit that is 1 stays 1.
- R6: With relax count R and strobe count T, busy is high for 2(R+1)+S cycles starting at the clock edge of the start write, where S = max(T-2(R+1), 1). `strobe_o` is high for the S cycles that follow the first R+1 busy cycles.
- R7: A program-data write while the key field is not 0x3E77 sets the error flag. It starts no operation and leaves the array unchanged.
- R8: A start (a program-data write, or a read-control write with bit 0 set) while busy or while the error flag is set is ignored and sets the error flag.
- R9: The error flag stays set until a write to offset 1 with bit 9 at 1. A write there with bit 9 at 0 leaves it set.
- R10: When a program cycle completes, control bits 31:16 return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| strobe_o | output | 1 | Fuse strobe, high during the strobe phase |

## Verification
Register writes take effect at the clock edge where `req_i` and `we_i` are high. Read data follows `addr_i` in the same cycle, so every readback is sampled at the falling edge after the address is set. Busy rises at the edge of the start write, so the bench counts busy and strobe cycles at each following falling edge until busy drops. It compares the total, the lead relax and the strobe counts against the R6 formula. The sense result and the cleared key are checked only after busy has dropped, because both are settled by the final tail edge.

// File: rtl/fuse_ctrl_pkg.sv
package fuse_ctrl_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam int CTRL_BUSY_BIT = 8;
  localparam int CTRL_ERR_BIT  = 9;

  typedef enum logic [2:0] {
    REG_CTRL     = 3'd0,
    REG_CTRL_CLR = 3'd1,
    REG_TIMING   = 3'd2,
    REG_RD_CTRL  = 3'd3,
    REG_PROG     = 3'd4,
    REG_SENSE    = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LEAD,
    PH_STROBE,
    PH_TAIL
  } phase_e;
endpackage

// File: rtl/fuse_phase_seq.sv
module fuse_phase_seq
  import fuse_ctrl_pkg::*;
#(
  parameter int TOT_W = 12,
  parameter int RLX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TOT_W-1:0] total_i,
  input  logic [RLX_W-1:0] relax_i,
  output logic             busy_o,
  output logic             strobe_o,
  output logic             strobe_last_o,
  output logic             done_o
);
  localparam int CNT_W = TOT_W + 1;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q, stb_q;
  logic [RLX_W-1:0] relax_q;
  logic [CNT_W-1:0] lead_w, both_w, tot_w, stb_w;

  // strobe length = total minus both relax windows, never below one cycle
  always_comb begin
    lead_w = CNT_W'(relax_i) + CNT_W'(1);
    both_w = lead_w << 1;
    tot_w  = CNT_W'(total_i);
    stb_w  = (tot_w > both_w) ? (tot_w - both_w) : CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      stb_q   <= '0;
      relax_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_LEAD;
          cnt_q   <= CNT_W'(relax_i);
          relax_q <= relax_i;
          stb_q   <= stb_w - CNT_W'(1);
        end
        PH_LEAD: if (cnt_q == '0) begin
          phase_q <= PH_STROBE;
          cnt_q   <= stb_q;
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_STROBE: if (cnt_q == '0) begin
          phase_q <= PH_TAIL;
          cnt_q   <= CNT_W'(relax_q);
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_TAIL: if (cnt_q == '0) phase_q <= PH_IDLE;
                 else cnt_q <= cnt_q - CNT_W'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o        = (phase_q != PH_IDLE);
  assign strobe_o      = (phase_q == PH_STROBE);
  assign strobe_last_o = strobe_o && (cnt_q == '0);
  assign done_o        = (phase_q == PH_TAIL) && (cnt_q == '0);

  // R8
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);

  // R6
  strobe_after_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_o) |-> $past(phase_q == PH_LEAD));
endmodule

// File: rtl/fuse_array_model.sv
module fuse_array_model #(
  parameter int WORDS  = 128,
  parameter int DATA_W = 32,
  parameter int AW     = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              sense_i,
  input  logic              prog_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sense_data_o
);
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] cur_word;

  assign cur_word = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      sense_data_o <= '0;
    end else begin
      if (prog_i) mem_q[addr_i] <= cur_word | data_i;  // fuses only set
      if (sense_i) sense_data_o <= cur_word;
    end
  end

  // R5
  no_unburn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> ((mem_q[$past(addr_i)] & $past(cur_word)) == $past(cur_word)));
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_ctrl_pkg::*;
#(
  parameter int NUM_BANKS  = 16,
  parameter int BANK_WORDS = 8,
  parameter int PROG_W     = 12,
  parameter int RLX_W      = 4,
  parameter int RD_W       = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        strobe_o
);
  localparam int WORDS     = NUM_BANKS * BANK_WORDS;
  localparam int AW        = $clog2(WORDS);
  localparam int RLX_LSB   = 12;
  localparam int RD_LSB    = 16;

  logic [15:0]       unlock_q;
  logic [AW-1:0]     addr_q;
  logic              err_q, op_prog_q;
  logic [PROG_W-1:0] prog_t_q;
  logic [RLX_W-1:0]  rlx_q;
  logic [RD_W-1:0]   rd_t_q;
  logic [31:0]       data_q;
  logic [31:0]       sense_data;
  logic              busy, strobe_last, seq_done;
  logic              wr, start_sense, start_prog, start_any, start_req, err_set, err_clr;
  logic [PROG_W-1:0] seq_total;
  reg_sel_e          sel;

  assign sel         = reg_sel_e'(addr_i);
  assign wr          = req_i && we_i;
  assign start_req   = wr && ((sel == REG_RD_CTRL && wdata_i[0]) || sel == REG_PROG);
  assign start_sense = wr && sel == REG_RD_CTRL && wdata_i[0] && !busy && !err_q;
  assign start_prog  = wr && sel == REG_PROG && !busy && !err_q && unlock_q == UNLOCK_KEY;
  assign start_any   = start_sense || start_prog;
  assign err_set     = start_req && !start_any;
  assign err_clr     = wr && sel == REG_CTRL_CLR && wdata_i[CTRL_ERR_BIT];
  assign seq_total   = start_prog ? prog_t_q : PROG_W'(rd_t_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q  <= '0;
      addr_q    <= '0;
      err_q     <= 1'b0;
      op_prog_q <= 1'b0;
      prog_t_q  <= '0;
      rlx_q     <= '0;
      rd_t_q    <= '0;
      data_q    <= '0;
    end else begin
      if (wr && sel == REG_CTRL && !busy) begin
        unlock_q <= wdata_i[31:16];
        addr_q   <= wdata_i[AW-1:0];
      end else if (seq_done && op_prog_q) begin
        unlock_q <= '0;  // every program needs a fresh unlock
      end
      if (wr && sel == REG_TIMING && !busy) begin
        prog_t_q <= wdata_i[PROG_W-1:0];
        rlx_q    <= wdata_i[RLX_LSB +: RLX_W];
        rd_t_q   <= wdata_i[RD_LSB +: RD_W];
      end
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (start_any) op_prog_q <= start_prog;
      if (start_prog) data_q <= wdata_i;
    end
  end

  fuse_phase_seq #(.TOT_W(PROG_W), .RLX_W(RLX_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_any),
    .total_i       (seq_total),
    .relax_i       (rlx_q),
    .busy_o        (busy),
    .strobe_o      (strobe_o),
    .strobe_last_o (strobe_last),
    .done_o        (seq_done)
  );

  fuse_array_model #(.WORDS(WORDS), .DATA_W(32), .AW(AW)) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (addr_q),
    .sense_i      (strobe_last && !op_prog_q),
    .prog_i       (strobe_last && op_prog_q),
    .data_i       (data_q),
    .sense_data_o (sense_data)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_CTRL, REG_CTRL_CLR: begin
        rdata_o[31:16]         = unlock_q;
        rdata_o[CTRL_ERR_BIT]  = err_q;
        rdata_o[CTRL_BUSY_BIT] = busy;
        rdata_o[AW-1:0]        = addr_q;
      end
      REG_TIMING: begin
        rdata_o[PROG_W-1:0]        = prog_t_q;
        rdata_o[RLX_LSB +: RLX_W]  = rlx_q;
        rdata_o[RD_LSB +: RD_W]    = rd_t_q;
      end
      REG_SENSE: rdata_o = sense_data;
      default:   rdata_o = '0;
    endcase
  end

  // R8
  busy_start_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == REG_PROG && busy) |=> err_q);

  // R9
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_q) |-> $past(wr && sel == REG_CTRL_CLR && wdata_i[CTRL_ERR_BIT]));

  // R10
  unlock_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_done && op_prog_q) |=> (unlock_q == '0));

  // R6
  strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> busy);

  // R7
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == REG_PROG && !busy && unlock_q != UNLOCK_KEY) |=> !busy);
endmodule

// File: tb/fuse_ctrl_test.sv
module fuse_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        strobe;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] model [128];

  always #4 clk = ~clk;  // 125 MHz

  fuse_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .strobe_o(strobe)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0; addr = 3'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
    addr = 3'd0;
  endtask

  // counts busy cycles after a start write, plus lead and strobe cycles
  task automatic measure(output int tot, output int lead, output int stb);
    tot = 0; lead = 0; stb = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (!rdata[8]) break;
      tot++;
      if (strobe) stb++;
      else if (stb == 0) lead++;
    end
  endtask

  function automatic int exp_stb(input int t, input int r);
    return (t > 2 * (r + 1)) ? t - 2 * (r + 1) : 1;
  endfunction

  function automatic logic [31:0] timing_word(input int p, input int r, input int s);
    return {10'd0, 6'(s), 4'(r), 12'(p)};
  endfunction

  task automatic prog_word(input int a, input logic [31:0] d, input int p, input int r, input string tag);
    int tot, lead, stb;
    wr(3'd0, {16'h3E77, 9'd0, 7'(a)});
    wr(3'd4, d);
    measure(tot, lead, stb);
    model[a] = model[a] | d;
    chk({tag, " R6 total"}, 32'(tot), 32'(2 * (r + 1) + exp_stb(p, r)));
    chk({tag, " R6 lead"}, 32'(lead), 32'(r + 1));
    chk({tag, " R6 strobe"}, 32'(stb), 32'(exp_stb(p, r)));
  endtask

  task automatic sense_word(input int a, input int s, input int r, input string tag);
    int tot, lead, stb;
    logic [31:0] v;
    wr(3'd0, {16'h0, 9'd0, 7'(a)});
    wr(3'd3, 32'd1);
    measure(tot, lead, stb);
    chk({tag, " R6 sense total"}, 32'(tot), 32'(2 * (r + 1) + exp_stb(s, r)));
    rd(3'd5, v);
    chk({tag, " R4 sense data"}, v, model[a]);
  endtask

  initial begin
    logic [31:0] v;
    int tot, lead, stb;
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(3'd2, v); chk("R1 timing", v, 32'h0);
    rd(3'd5, v); chk("R1 sense", v, 32'h0);
    chk("R1 strobe", 32'(strobe), 32'h0);

    // R3 timing layout
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R3 timing mask", v, 32'h003F_FFFF);
    wr(3'd2, timing_word(20, 2, 9));
    rd(3'd2, v); chk("R3 timing fields", v, timing_word(20, 2, 9));

    // R2 ctrl layout: bank 5 word 3 -> 43; flag bits read-only
    wr(3'd0, {16'h1234, 6'd0, 2'b11, 1'b0, 7'd43});
    rd(3'd0, v); chk("R2 ctrl fields", v, {16'h1234, 9'd0, 7'd43});

    // R7 wrong key
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R7 err set no busy", v & 32'h300, 32'h200);
    // R9 write with bit 9 low keeps error
    wr(3'd1, 32'h0);
    rd(3'd0, v); chk("R9 err held", v & 32'h200, 32'h200);
    wr(3'd1, 32'h200);
    rd(3'd0, v); chk("R9 err cleared", v & 32'h200, 32'h0);
    sense_word(43, 9, 2, "wrong key");  // R7 array unchanged

    // R5/R6/R10 directed program and OR behaviour
    prog_word(43, 32'h0000_00F0, 20, 2, "dir1");
    rd(3'd0, v); chk("R10 unlock cleared", v[31:16], 32'h0);
    prog_word(43, 32'h0000_0F0F, 20, 2, "dir2");
    sense_word(43, 9, 2, "dir R5 or");
    chk("R5 or value", model[43], 32'h0000_0FFF);

    // R10 program without new unlock is rejected
    wr(3'd4, 32'h1);
    rd(3'd0, v); chk("R10 relock err", v & 32'h300, 32'h200);
    wr(3'd1, 32'h200);

    // R6 minimal counts: relax 0, strobe 0 -> 3 cycles, 1 strobe
    wr(3'd2, timing_word(0, 0, 0));
    prog_word(7, 32'h8000_0001, 0, 0, "min");
    sense_word(7, 0, 0, "min");

    // R8 start while busy; R2/R3 writes while busy ignored
    wr(3'd2, timing_word(40, 1, 6));
    wr(3'd0, {16'h3E77, 9'd0, 7'd100});
    wr(3'd4, 32'h00AA_0000);
    model[100] = model[100] | 32'h00AA_0000;
    wr(3'd3, 32'd1);
    wr(3'd0, {16'h3E77, 9'd0, 7'd5});
    wr(3'd2, timing_word(1, 1, 1));
    measure(tot, lead, stb);
    rd(3'd0, v); chk("R8 err after busy start", v & 32'h300, 32'h200);
    chk("R2 addr kept while busy", v[6:0], 32'd100);
    rd(3'd2, v); chk("R3 timing kept while busy", v, timing_word(40, 1, 6));
    // R8 start while error set is ignored
    wr(3'd3, 32'd1);
    rd(3'd0, v); chk("R8 no busy with err", v & 32'h300, 32'h200);
    wr(3'd1, 32'h200);
    sense_word(100, 6, 1, "busy test");

    // random programs and senses
    for (int it = 0; it < 40; it++) begin
      int p, r, s, a;
      logic [31:0] d;
      p = $urandom_range(0, 60);
      r = $urandom_range(0, 3);
      s = $urandom_range(0, 40);
      a = $urandom_range(0, 15) * 8 + $urandom_range(0, 7);
      d = $urandom();
      wr(3'd2, timing_word(p, r, s));
      if (it % 8 == 0) begin
        wr(3'd0, {16'h3E76, 9'd0, 7'(a)});
        wr(3'd4, d);
        rd(3'd0, v); chk("R7 rnd bad key", v & 32'h300, 32'h200);
        wr(3'd1, 32'h200);
      end
      prog_word(a, d, p, r, "rnd");
      rd(3'd0, v); chk("R10 rnd unlock", v[31:16], 32'h0);
      sense_word(a, s, r, "rnd");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule